// File: doc/BRIEF.md
# Master/slave synchronous serial shifter

An 8-bit synchronous serial port built around a single shift register. Software reaches the block through a small register bus with two locations: the data location reads and writes the shift register, and the control location holds a mode bit and a 4-bit rate select. Data leaves on the serial output most significant bit first and arrives on the serial input. Outgoing data changes on the falling edge of the shift clock, and incoming data is captured on the rising edge.

In master mode the block makes its own shift clock. The clock comes either from a power-of-two prescaler of the system clock or from an external timer-underflow pulse. The block drives the clock pin and stops the clock, high, after eight bits. In slave mode an external shift clock is brought into the system clock domain through a two-flop synchroniser, and its edges are detected. The clock output is then not driven. A mode pin shows which role is active, and a done flag marks a finished byte.

Top module: `sio_shifter`

## Requirements
- R1: After reset the block is in slave mode: sck_o=1, sck_oe_o=0, master_o=0, done_o=0, sdo_o=1, and both register locations read 0.
- R2: Writing address 1 sets the mode from bit 4 (1 = master) and the rate select from bits 3:0. The location reads back as {3'b0, mode, select}. master_o and sck_oe_o both equal the mode bit.
- R3: Address 0 reads and writes the shift register. When no transfer is running, a read returns the last value written.
- R4: For a select value s below DIV_STEPS, every master shift-clock half period lasts 2^(DIV_BASE_EXP+s-1) system cycles, so the full period is 2^(DIV_BASE_EXP+s). The first falling edge comes one half period after the data write. Select values above DIV_STEPS use the slowest ratio (s = DIV_STEPS-1).
- R5: With select equal to DIV_STEPS, each single-cycle tmr_uflow_i pulse during a master transfer toggles sck_o on the next clock, and the prescaler does not toggle it.
- R6: Bits leave on sdo_o MSB first. sdo_o changes only when the master shift clock falls, and sdi_i is captured when it rises. After eight rising edges address 0 holds the received byte.
- R7: After the eighth rising edge, done_o=1 and the master clock stays high with no further edges. done_o stays set until the next data write.
- R8: A data write clears done_o. In master mode it also starts a transfer. In slave mode it only preloads the register and sck_o stays high.
- R9: In slave mode sck_i is synchronised and its falling and rising edges shift data in the same way. done_o rises after eight rising edges. sck_oe_o stays 0 and sck_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = shift data, 1 = control |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational on address) |
| tmr_uflow_i | input | 1 | Timer-underflow pulse, used as the clock source when select = DIV_STEPS |
| sck_i | input | 1 | External shift clock for slave mode |
| sdi_i | input | 1 | Serial data in |
| sck_o | output | 1 | Shift clock out, idle high |
| sck_oe_o | output | 1 | Output enable for sck_o, low in slave mode |
| sdo_o | output | 1 | Serial data out |
| master_o | output | 1 | Mode indicator, 1 = master |
| done_o | output | 1 | Byte complete flag |

## Verification
The bench builds the block with DIV_BASE_EXP=2 and DIV_STEPS=6. With these values the half periods run from 2 to 64 cycles, and a complete master byte at every one of the 16 select codes finishes in a few thousand cycles. The sweep therefore covers every prescaler step, the timer-pulse code, and all the codes above it that fall back to the slowest ratio. Each transfer measures every half period and checks both data directions. A slave transfer with a slow external clock covers the synchroniser path and the preload-only write.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned SEL_W = 4;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  typedef struct packed {
    logic             master;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int unsigned BASE_EXP = 4,
  parameter int unsigned STEPS    = 14
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      run_i,
  input  logic                      restart_i,
  input  logic [sio_pkg::SEL_W-1:0] sel_i,
  input  logic                      tmr_i,
  output logic                      tick_o
);
  localparam int unsigned TOP_EXP = BASE_EXP + STEPS - 2;
  localparam int unsigned CW      = (TOP_EXP > 0) ? TOP_EXP : 1;

  logic [CW-1:0]    cnt_q;
  logic [STEPS-1:0] hit;
  logic             raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + 1'b1;
  end

  // step s toggles every 2^(BASE_EXP+s-1) cycles
  for (genvar s = 0; s < STEPS; s++) begin : g_step
    localparam int unsigned E = BASE_EXP + s - 1;
    if (E == 0) begin : g_every
      assign hit[s] = 1'b1;
    end else begin : g_mask
      assign hit[s] = &cnt_q[E-1:0];
    end
  end

  always_comb begin
    raw = hit[STEPS-1];
    if (sel_i == sio_pkg::SEL_W'(STEPS)) raw = tmr_i;
    else begin
      for (int s = 0; s < STEPS; s++)
        if (sel_i == sio_pkg::SEL_W'(s)) raw = hit[s];
    end
  end

  assign tick_o = run_i & raw;
endmodule

// File: rtl/sio_sync_edge.sv
module sio_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= 3'b111;
    else         sh_q <= {sh_q[1:0], async_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
  assign fall_o = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sdo_o,
  output logic              last_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sdo_q;
  logic              at_end;

  assign at_end = (cnt_q == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      sdo_q  <= 1'b1;
    end else if (load_i) begin
      sreg_q <= load_data_i;
      cnt_q  <= '0;
    end else if (rise_i) begin
      sreg_q <= {sreg_q[DATA_W-2:0], sdi_i};
      cnt_q  <= at_end ? '0 : cnt_q + 1'b1;
    end else if (fall_i) begin
      sdo_q  <= sreg_q[DATA_W-1];
    end
  end

  assign data_o = sreg_q;
  assign sdo_o  = sdo_q;
  assign last_o = rise_i & ~load_i & at_end;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned DIV_BASE_EXP = 4,
  parameter int unsigned DIV_STEPS    = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              tmr_uflow_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              sdo_o,
  output logic              master_o,
  output logic              done_o
);
  import sio_pkg::*;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic              busy_q, sck_q, done_q;
  logic              load, start, tick, last;
  logic              m_rise, m_fall, s_rise, s_fall;
  logic [DATA_W-1:0] data;

  assign load  = reg_we_i & (reg_addr_i == ADDR_DATA);
  assign start = load & ctrl_q.master;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (reg_we_i && reg_addr_i == ADDR_CTRL)
      ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  end

  sio_clkgen #(.BASE_EXP(DIV_BASE_EXP), .STEPS(DIV_STEPS)) i_clkgen (
    .clk_i, .rst_ni,
    .run_i    (busy_q),
    .restart_i(start),
    .sel_i    (ctrl_q.sel),
    .tmr_i    (tmr_uflow_i),
    .tick_o   (tick)
  );

  sio_sync_edge i_sync (
    .clk_i, .rst_ni,
    .async_i(sck_i),
    .rise_o (s_rise),
    .fall_o (s_fall)
  );

  assign m_fall = busy_q & tick & sck_q;
  assign m_rise = busy_q & tick & ~sck_q;

  sio_shift_core #(.DATA_W(DATA_W)) i_core (
    .clk_i, .rst_ni,
    .load_i     (load),
    .load_data_i(reg_wdata_i),
    .rise_i     (ctrl_q.master ? m_rise : s_rise),
    .fall_i     (ctrl_q.master ? m_fall : s_fall),
    .sdi_i,
    .data_o     (data),
    .sdo_o,
    .last_o     (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      if (!ctrl_q.master)   busy_q <= 1'b0;
      else if (start)       busy_q <= 1'b1;
      else if (last)        busy_q <= 1'b0;

      if (!ctrl_q.master || start) sck_q <= 1'b1;
      else if (busy_q && tick)     sck_q <= ~sck_q;

      if (load)      done_q <= 1'b0;
      else if (last) done_q <= 1'b1;
    end
  end

  assign reg_rdata_o = (reg_addr_i == ADDR_CTRL) ? DATA_W'(ctrl_q) : data;
  assign sck_o       = sck_q;
  assign sck_oe_o    = ctrl_q.master;
  assign master_o    = ctrl_q.master;
  assign done_o      = done_q;
endmodule

module sio_shifter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic reg_we_i,
  input logic reg_addr_i,
  input logic sck_o,
  input logic sck_oe_o,
  input logic sdo_o,
  input logic master_o,
  input logic done_o
);
  a_r2_oe_follows_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_oe_o == master_o);

  a_r9_slave_clock_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_o |-> sck_o);

  a_r6_sdo_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_o && $past(master_o) && !$fell(sck_o)) |-> $stable(sdo_o));

  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(reg_we_i && reg_addr_i == 1'b0)) |=> done_o);

  a_r7_done_clock_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_o && done_o) |-> sck_o);

  a_r8_write_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 1'b0) |=> !done_o);
endmodule

bind sio_shifter sio_shifter_chk i_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i,
  .sck_o, .sck_oe_o, .sdo_o, .master_o, .done_o
);

// File: tb/test_sio_shifter.sv
`timescale 1ns/1ps
module test_sio_shifter;
  localparam int BASE  = 2;
  localparam int STEPS = 6;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0, addr = 1'b0, tmr = 1'b0, sck_in = 1'b1, sdi = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck, sck_oe, sdo, mst, done;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  sio_shifter #(.DATA_W(8), .DIV_BASE_EXP(BASE), .DIV_STEPS(STEPS)) i_sio_shifter (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tmr_uflow_i(tmr),
    .sck_i(sck_in), .sdi_i(sdi), .sck_o(sck), .sck_oe_o(sck_oe),
    .sdo_o(sdo), .master_o(mst), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic int half_of(input int s);
    if (s > STEPS) return 1 << (BASE + STEPS - 2);
    return 1 << (BASE + s - 1);
  endfunction

  task automatic run_master(input int s, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] got = '0, back;
    int h = half_of(s), n = 0, rises = 0, falls = 0, bad = 0, guard = 0, stray = 0;
    logic prev;
    wr(1'b1, {3'b000, 1'b1, 4'(s)});
    wr(1'b0, tx);
    chk("R8 start clears done", done, 0);
    prev = sck;
    while (rises < 8 && guard < 8000) begin
      @(negedge clk);
      n++; guard++;
      if (sck != prev) begin
        if (n != h) bad++;
        n = 0; prev = sck;
        if (!sck) begin sdi = rx[7-falls]; falls++; end
        else begin got = {got[6:0], sdo}; rises++; end
      end
    end
    chk($sformatf("R4 half period sel=%0d", s), bad, 0);
    chk($sformatf("R6 sent byte sel=%0d", s), got, tx);
    chk("R7 done after 8 rises", done, 1);
    repeat (4 * h) begin
      @(negedge clk);
      if (sck != 1'b1) stray++;
    end
    chk("R7 clock held high", stray, 0);
    rd(1'b0, back);
    chk($sformatf("R6 received byte sel=%0d", s), back, rx);
  endtask

  task automatic run_timer(input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] got = '0, back;
    int rises = 0, falls = 0, bad = 0, stray = 0;
    logic prev;
    wr(1'b1, {3'b000, 1'b1, 4'(STEPS)});
    wr(1'b0, tx);
    prev = sck;
    for (int t = 0; t < 16; t++) begin
      repeat (5) begin
        @(negedge clk);
        if (sck != prev) stray++;
      end
      tmr = 1'b1;
      @(negedge clk);
      tmr = 1'b0;
      if (sck == prev) bad++;
      prev = sck;
      if (!sck) begin sdi = rx[7-falls]; falls++; end
      else begin got = {got[6:0], sdo}; rises++; end
    end
    chk("R5 timer pulses toggle clock", bad, 0);
    chk("R5 no prescaler toggles", stray, 0);
    chk("R6 timer sent byte", got, tx);
    chk("R7 timer done", done, 1);
    tmr = 1'b1;
    @(negedge clk);
    tmr = 1'b0;
    @(negedge clk);
    chk("R7 pulse after done ignored", sck, 1);
    rd(1'b0, back);
    chk("R6 timer received byte", back, rx);
  endtask

  task automatic run_slave(input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] got = '0, back;
    int bad = 0;
    wr(1'b1, 8'h00);
    chk("R2 slave mode pin", mst, 0);
    chk("R2 slave oe", sck_oe, 0);
    wr(1'b0, tx);
    chk("R8 slave write clears done", done, 0);
    repeat (40) begin
      @(negedge clk);
      if (sck != 1'b1 || done) bad++;
    end
    chk("R8 slave write only preloads", bad, 0);
    rd(1'b0, back);
    chk("R3 preload readback", back, tx);
    bad = 0;
    for (int b = 0; b < 8; b++) begin
      sck_in = 1'b0; sdi = rx[7-b];
      repeat (4) @(negedge clk);
      got = {got[6:0], sdo};
      if (sck != 1'b1 || sck_oe != 1'b0) bad++;
      sck_in = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk("R9 slave sent byte", got, tx);
    chk("R9 slave pin not driven", bad, 0);
    chk("R9 slave done", done, 1);
    rd(1'b0, back);
    chk("R9 slave received byte", back, rx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1 sck_o", sck, 1);
    chk("R1 sck_oe_o", sck_oe, 0);
    chk("R1 master_o", mst, 0);
    chk("R1 done_o", done, 0);
    chk("R1 sdo_o", sdo, 1);
    rd(1'b0, v); chk("R1 data reads 0", v, 0);
    rd(1'b1, v); chk("R1 ctrl reads 0", v, 0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(1'b1, 8'h13);
    rd(1'b1, v); chk("R2 ctrl readback", v, 8'h13);
    chk("R2 master pin", mst, 1);
    chk("R2 master oe", sck_oe, 1);
    wr(1'b1, 8'h0A);
    rd(1'b1, v); chk("R2 ctrl readback slave", v, 8'h0A);
    wr(1'b0, 8'h6C);
    rd(1'b0, v); chk("R3 data readback", v, 8'h6C);
    for (int s = 0; s < 16; s++) begin
      logic [7:0] tx, rx;
      tx = 8'hA5 ^ 8'(s * 8'h1D);
      rx = {tx[3:0], tx[7:4]} ^ 8'h3C;
      if (s == STEPS) run_timer(tx, rx);
      else            run_master(s, tx, rx);
    end
    run_master(0, 8'h00, 8'hFF);
    run_master(1, 8'hFF, 8'h00);
    run_slave(8'hC3, 8'h5A);
    run_slave(8'h81, 8'h7E);
    wr(1'b0, 8'h11);
    chk("R8 write after done clears it", done, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule